// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause 22 management-bus master. Software programs it through two 32-bit registers selected by a one-bit address. A control word holds the enable and the clock divider, and reports whether a frame is on the wire. A command word carries the start flag, the direction, both addresses and the data. The block serialises a 64-bit frame on MDC and MDIO and drives the output-enable of an external tri-state pad. On reads it releases the line, samples the PHY's turnaround acknowledge and the 16 data bits, and writes them back into the same command word.

A transaction starts when software writes the command word with its start flag set. The flag stays set while the frame is pending or running, and it clears by itself when the last bit period ends, so software polls it to detect completion. Register writes are accepted in the cycle they are presented and have no back-pressure. The block has no streaming interface.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle set, enable clear, divider 0), the command word reads 0, MDC is low and the output-enable is low.
- R2: With divider value D, one MDC period lasts P system cycles, where P = 2 if D = 0 and P = D + 1 otherwise. MDC is low for the first (P+1)/2 cycles of each bit period and high for the rest, and it stays low between frames.
- R3: A frame begins one cycle after the start flag and enable are both seen with no frame running. It opens with 32 bits of one, followed by the start pattern 0 then 1. Each bit changes at the start of its low phase.
- R4: The opcode follows the start pattern: 1,0 for a read and 0,1 for a write. It is followed by the PHY address (command bits 20:16) and then the register address (command bits 25:21), each sent MSB first.
- R5: A write drives the line for all 64 bits, sends turnaround as 1,0 and then the 16 data bits (command bits 15:0) MSB first.
- R6: A read drops output-enable from the first turnaround bit (bit 46) to the end of the frame. It samples MDIO in the cycle at whose end MDC rises, and collects the 16 data bits MSB first into command bits 15:0.
- R7: After a read, the acknowledge flag (command bit 29) is 1 exactly when the second turnaround bit was sampled low. A write leaves the flag at 0, and any accepted command write clears it.
- R8: The start flag (command bit 31) is set by a command write with bit 31 high, and clears in the cycle that the 64th bit period ends. Bit 30 selects write (1) or read (0).
- R9: A command write presented while the start flag is set is ignored. The command word is unchanged at the end of the frame apart from the read results.
- R10: With enable (control bit 30) clear, no frame starts and a set start flag stays pending. Clearing enable during a frame lets that frame finish, after which idle reads 1.
- R11: The divider is captured when a frame starts. A divider write during a frame changes only the timing of later frames.
- R12: Control bit 31 reads 1 exactly when no frame is running, and writes to it have no effect. Control bits 15:0 read back the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 control word, 1 command word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on the MDIO pad |
| mdio_oe | output | 1 | Output-enable of the MDIO pad |
| mdio_i | input | 1 | Value seen on the MDIO pad |

## Verification
Writes and reads run with dividers 0, 1, 2, 3 and 5. The even and odd periods show whether the low phase takes the longer half, and dividers 0 and 1 show that both collapse to a two-cycle period. Reads run against a responding PHY with asymmetric data patterns, which catches bit-order and shift errors, and against an absent PHY that leaves the line high, which separates acknowledge from data. Further sequences send a command write during a running frame, clear enable mid-frame and with a command pending, change the divider mid-frame, and write the idle bit. Each one checks that state cannot leak across the frame boundary.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int AW        = 5;
  localparam int DW        = 16;
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;

  localparam int CTL_IDLE  = 31;
  localparam int CTL_EN    = 30;
  localparam int UA_GO     = 31;
  localparam int UA_WR     = 30;
  localparam int UA_ACK    = 29;
  localparam int UA_REG_LO = 21;
  localparam int UA_PHY_LO = 16;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] regad;
    logic [AW-1:0] phy;
    logic [DW-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             mdc,
  output logic             rise_p,
  output logic             end_p
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per_m1_q;
  logic [DIV_W-1:0] low_m1_q;
  logic [DIV_W-1:0] per_m1_d;

  always_comb begin
    per_m1_d = (div_val == '0) ? DIV_W'(1) : div_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_m1_q <= DIV_W'(1);
      low_m1_q <= '0;
    end else if (start) begin
      cnt_q    <= '0;
      per_m1_q <= per_m1_d;
      low_m1_q <= per_m1_d >> 1;
    end else if (run) begin
      cnt_q <= end_p ? '0 : cnt_q + DIV_W'(1);
    end
  end

  assign mdc    = run && (cnt_q > low_m1_q);
  assign rise_p = run && (cnt_q == low_m1_q);
  assign end_p  = run && (cnt_q == per_m1_q);

  // R2: the phase counter never passes the period end
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= per_m1_q));
  // R2: each bit period opens with MDC low
  a_r2_low_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    end_p |=> !mdc);
  // R11: the captured period holds for the whole frame
  a_r11_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> $stable(per_m1_q));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  mdio_cmd_t     cmd,
  input  logic          rise_p,
  input  logic          end_p,
  input  logic          mdio_i,
  output logic          busy,
  output logic          done,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          ta_low,
  output logic [DW-1:0] rdata
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q;
  logic [FRAME_LEN-1:0] fw;
  logic [1:0]           op_bits;
  logic [1:0]           ta_bits;
  logic [DW-1:0]        tail_bits;

  always_comb begin
    op_bits   = cmd.wr ? 2'b01 : 2'b10;
    ta_bits   = cmd.wr ? 2'b10 : 2'b11;
    tail_bits = cmd.wr ? cmd.data : '1;
    fw        = {{PRE_LEN{1'b1}}, 2'b01, op_bits, cmd.phy, cmd.regad, ta_bits, tail_bits};
  end

  assign busy    = busy_q;
  assign done    = end_p && (idx_q == IDX_W'(FRAME_LEN - 1));
  assign mdio_o  = busy_q ? fw[IDX_W'(FRAME_LEN - 1) - idx_q] : 1'b1;
  assign mdio_oe = busy_q && (cmd.wr || (idx_q < IDX_W'(TA_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      ta_low <= 1'b0;
      rdata  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      ta_low <= 1'b0;
      rdata  <= '0;
    end else if (busy_q) begin
      if (rise_p) begin
        if (idx_q == IDX_W'(TA_IDX + 1)) ta_low <= !mdio_i;
        if (idx_q >= IDX_W'(DATA_IDX))   rdata  <= {rdata[DW-2:0], mdio_i};
      end
      if (end_p) begin
        if (done) busy_q <= 1'b0;
        else      idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  // R3: a start is only issued to an idle sequencer
  a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R3: every frame opens at bit zero
  a_r3_opens_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (idx_q == '0));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int              DIV_W   = 16,
  parameter logic [DIV_W-1:0] RST_DIV = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             en_q, go_q, ack_q;
  logic [DIV_W-1:0] div_q;
  mdio_cmd_t        cmd_q;
  logic             busy, done, start, rise_p, end_p, ta_low;
  logic [DW-1:0]    rd_bits;
  logic [31:0]      ctl_word, ua_word;

  assign start = go_q && en_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= RST_DIV;
      go_q  <= 1'b0;
      ack_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (reg_wr && !reg_addr) begin
        en_q  <= reg_wdata[CTL_EN];
        div_q <= reg_wdata[DIV_W-1:0];
      end
      if (reg_wr && reg_addr && !go_q) begin
        go_q        <= reg_wdata[UA_GO];
        ack_q       <= 1'b0;
        cmd_q.wr    <= reg_wdata[UA_WR];
        cmd_q.regad <= reg_wdata[UA_REG_LO +: AW];
        cmd_q.phy   <= reg_wdata[UA_PHY_LO +: AW];
        cmd_q.data  <= reg_wdata[DW-1:0];
      end
      if (done) begin
        go_q <= 1'b0;
        if (!cmd_q.wr) begin
          ack_q      <= ta_low;
          cmd_q.data <= rd_bits;
        end
      end
    end
  end

  always_comb begin
    ctl_word              = '0;
    ctl_word[CTL_IDLE]    = !busy;
    ctl_word[CTL_EN]      = en_q;
    ctl_word[DIV_W-1:0]   = div_q;
    ua_word               = '0;
    ua_word[UA_GO]        = go_q;
    ua_word[UA_WR]        = cmd_q.wr;
    ua_word[UA_ACK]       = ack_q;
    ua_word[UA_REG_LO +: AW] = cmd_q.regad;
    ua_word[UA_PHY_LO +: AW] = cmd_q.phy;
    ua_word[DW-1:0]       = cmd_q.data;
    reg_rdata             = reg_addr ? ua_word : ctl_word;
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) clkgen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .run     (busy),
    .div_val (div_q),
    .mdc     (mdc),
    .rise_p  (rise_p),
    .end_p   (end_p)
  );

  mdio_frame_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd     (cmd_q),
    .rise_p  (rise_p),
    .end_p   (end_p),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .done    (done),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .ta_low  (ta_low),
    .rdata   (rd_bits)
  );

  // R8: the start flag is down once the frame engine stops
  a_r8_go_clears_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !go_q);
  // R9: command fields are frozen while the start flag is set
  a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !done) |=> ($stable(cmd_q.phy) && $stable(cmd_q.regad) && $stable(cmd_q.wr)));
  // R10: nothing starts while disabled
  a_r10_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy) |=> !busy);
  // R5: a write frame keeps the pad driven throughout
  a_r5_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_q.wr) |-> mdio_oe);
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int          m_div, t, per, lowc;
  logic        m_en, m_go, m_wr, m_ack, m_busy, m_ta_low;
  logic [4:0]  m_phy, m_reg;
  logic [15:0] m_data, m_shift;
  // PHY stand-in
  logic        phy_on = 1'b0;
  logic [15:0] phy_val = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ua(logic go, logic wr, logic ack, logic [4:0] rg,
                                     logic [4:0] ph, logic [15:0] d);
    return {go, wr, ack, 3'b000, rg, ph, d};
  endfunction

  function automatic logic frame_bit(int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return !m_wr;
    if (b == 35) return m_wr;
    if (b < 41) return m_phy[40 - b];
    if (b < 46) return m_reg[45 - b];
    if (b == 46) return 1'b1;
    if (b == 47) return !m_wr;
    return m_data[63 - b];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; t = 0; per = 2; lowc = 1;
      m_en = 0; m_go = 0; m_wr = 0; m_ack = 0; m_busy = 0; m_ta_low = 0;
      m_phy = 0; m_reg = 0; m_data = 0; m_shift = 0;
    end else begin
      logic pre_go, pre_en;
      pre_go = m_go;
      pre_en = m_en;
      if (m_busy) begin
        if ((t % per) == lowc - 1) begin
          if ((t / per) == 47) m_ta_low = !mdio_i;
          if ((t / per) >= 48) m_shift = {m_shift[14:0], mdio_i};
        end
        if (t == 64 * per - 1) begin
          m_busy = 0;
          m_go = 0;
          if (!m_wr) begin
            m_ack = m_ta_low;
            m_data = m_shift;
          end
        end else begin
          t++;
        end
      end else if (pre_go && pre_en) begin
        m_busy = 1; t = 0;
        per = (m_div == 0) ? 2 : m_div + 1;
        lowc = (per + 1) / 2;
        m_shift = 0; m_ta_low = 0;
      end
      if (reg_wr) begin
        if (!reg_addr) begin
          m_en = reg_wdata[30];
          m_div = int'(reg_wdata[15:0]);
        end else if (!pre_go) begin
          m_go = reg_wdata[31]; m_wr = reg_wdata[30]; m_ack = 0;
          m_reg = reg_wdata[25:21]; m_phy = reg_wdata[20:16]; m_data = reg_wdata[15:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int b;
      logic e_mdc, e_oe;
      logic [31:0] e_rd;
      b = t / per;
      e_mdc = m_busy && ((t % per) >= lowc);
      e_oe = m_busy && (m_wr || b < 46);
      chk("R2 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk(m_wr ? "R5 mdio_oe" : "R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe)
        chk(b < 32 ? "R3 mdio_o" : (b < 46 ? "R4 mdio_o" : "R5 mdio_o"),
            {31'b0, mdio_o}, {31'b0, frame_bit(b)});
      if (reg_addr) e_rd = ua(m_go, m_wr, m_ack, m_reg, m_phy, m_data);
      else          e_rd = {!m_busy, m_en, 14'b0, m_div[15:0]};
      chk(reg_addr ? "R8 command word" : "R12 control word", reg_rdata, e_rd);
      if (m_busy && !m_wr && b >= 46 && phy_on)
        mdio_i = (b == 46) ? 1'b1 : ((b == 47) ? 1'b0 : phy_val[63 - b]);
      else
        mdio_i = 1'b1;
    end
  end

  task automatic wr_reg(logic a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic idle_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_go_clear();
    for (int i = 0; i < 40000 && m_go; i++) @(posedge clk);
    #1;
  endtask

  task automatic rd_chk(logic a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual still running expected finished");
    finish_run();
  end

  initial begin
    idle_cyc(4);
    @(posedge clk); #1 rst_n = 1'b1;
    // R1 reset state
    rd_chk(1'b0, 32'h8000_0000, "R1 control after reset");
    rd_chk(1'b1, 32'h0, "R1 command after reset");
    chk("R1 mdc", {31'b0, mdc}, 32'h0);
    chk("R1 mdio_oe", {31'b0, mdio_oe}, 32'h0);

    // write frame, divider 0
    wr_reg(1'b0, 32'h4000_0000);
    wr_reg(1'b1, ua(1, 1, 0, 5'h13, 5'h05, 16'hA5C3));
    wait_go_clear();
    rd_chk(1'b1, ua(0, 1, 0, 5'h13, 5'h05, 16'hA5C3), "R5 R8 write done");

    // read with acknowledge
    phy_on = 1'b1; phy_val = 16'h1234;
    wr_reg(1'b1, ua(1, 0, 0, 5'h02, 5'h1F, 16'h0000));
    wait_go_clear();
    rd_chk(1'b1, ua(0, 0, 1, 5'h02, 5'h1F, 16'h1234), "R6 R7 read ack");

    // read with no PHY, odd period
    phy_on = 1'b0;
    wr_reg(1'b0, 32'h4000_0002);
    wr_reg(1'b1, ua(1, 0, 0, 5'h09, 5'h11, 16'h0000));
    wait_go_clear();
    rd_chk(1'b1, ua(0, 0, 0, 5'h09, 5'h11, 16'hFFFF), "R7 no acknowledge");

    // read with divider 3 and an ignored command write
    phy_on = 1'b1; phy_val = 16'hBEEF;
    wr_reg(1'b0, 32'h4000_0003);
    wr_reg(1'b1, ua(1, 0, 0, 5'h1A, 5'h0C, 16'h0000));
    idle_cyc(12);
    wr_reg(1'b1, ua(1, 1, 0, 5'h01, 5'h01, 16'h0000));
    rd_chk(1'b1, ua(1, 0, 0, 5'h1A, 5'h0C, 16'h0000), "R9 write during frame");
    wait_go_clear();
    rd_chk(1'b1, ua(0, 0, 1, 5'h1A, 5'h0C, 16'hBEEF), "R9 R2 read after ignored write");

    // clear enable mid-frame, then a pending command
    wr_reg(1'b0, 32'h4000_0000);
    phy_val = 16'h00F0;
    wr_reg(1'b1, ua(1, 0, 0, 5'h03, 5'h04, 16'h0000));
    idle_cyc(40);
    wr_reg(1'b0, 32'h0000_0000);
    wait_go_clear();
    rd_chk(1'b1, ua(0, 0, 1, 5'h03, 5'h04, 16'h00F0), "R10 frame finishes after disable");
    rd_chk(1'b0, 32'h8000_0000, "R10 idle after disabled frame");
    wr_reg(1'b1, ua(1, 1, 0, 5'h07, 5'h07, 16'h5555));
    idle_cyc(200);
    rd_chk(1'b1, ua(1, 1, 0, 5'h07, 5'h07, 16'h5555), "R10 command pending");
    rd_chk(1'b0, 32'h8000_0000, "R10 no frame while disabled");
    chk("R10 mdc quiet", {31'b0, mdc}, 32'h0);
    wr_reg(1'b0, 32'h4000_0001);
    wait_go_clear();
    rd_chk(1'b1, ua(0, 1, 0, 5'h07, 5'h07, 16'h5555), "R10 pending command runs");

    // idle bit is read-only
    wr_reg(1'b1, ua(1, 1, 0, 5'h0A, 5'h15, 16'h3C3C));
    idle_cyc(10);
    wr_reg(1'b0, 32'hC000_0001);
    rd_chk(1'b0, 32'h4000_0001, "R12 idle low during frame");
    wait_go_clear();
    rd_chk(1'b0, 32'hC000_0001, "R12 idle high after frame");

    // divider change mid-frame
    phy_val = 16'h8001;
    wr_reg(1'b1, ua(1, 0, 0, 5'h10, 5'h01, 16'h0000));
    idle_cyc(30);
    wr_reg(1'b0, 32'h4000_0005);
    wait_go_clear();
    rd_chk(1'b1, ua(0, 0, 1, 5'h10, 5'h01, 16'h8001), "R11 frame kept old divider");
    wr_reg(1'b1, ua(1, 1, 0, 5'h1F, 5'h00, 16'h0F0F));
    wait_go_clear();
    rd_chk(1'b1, ua(0, 1, 0, 5'h1F, 5'h00, 16'h0F0F), "R11 next frame uses new divider");

    idle_cyc(5);
    finish_run();
  end
endmodule